// File: doc/BRIEF.md
# Boundary Scan Test Port with Instruction Decoder

This block is a serial test port in the IEEE 1149.1 style. A sixteen-state controller advances on the rising edge of the test clock under the mode-select input. Around it sit a three-bit instruction register, a one-bit bypass stage and a parameterised chain of boundary cells. Each boundary cell sits between one core output and its pin. Each cell has a capture/shift stage and an update latch.

The active instruction is decoded into four controls. The first picks which data register sits between the serial input and the serial output. The second is a reset request to the core. The third forces all pin drivers off. The fourth makes the pins take their values from the boundary update latches instead of from the core.

The value captured into the instruction register is the high-impedance opcode. A board tester can therefore float every pin by stepping only through the instruction capture and update states, with no shifting. All updates of the instruction and of the boundary latches happen on the falling test-clock edge. The serial output also changes on the falling edge.

Top module: `scan_port`

## Requirements
- R1: The instruction register is 3 bits wide. Bits enter from `tdi` and leave on `tdo` least significant bit first.
- R2: After `trst_n` is asserted, or whenever the controller is in Test-Logic-Reset, the active instruction is 111 (BYPASS). Pins then follow the core (`pin_out`=`core_out`, `pin_oe`=`core_oe`) and `sys_rst_req` is 0.
- R3: Five consecutive rising `tck` edges with `tms`=1 bring the controller to Test-Logic-Reset from any state. Four such edges starting from Shift-DR do not.
- R4: Capture-IR loads 001, the HIGHZ opcode, so the shifted-out bits are 1,0,0. Passing through Capture-IR and Update-IR with no Shift-IR activates HIGHZ.
- R5: EXTEST (000) selects the boundary chain. It drives `pin_out` from the update latches, sets every `pin_oe` bit to 1 and raises `sys_rst_req`.
- R6: HIGHZ (001) selects the bypass stage, forces `pin_oe` to all zeros and raises `sys_rst_req`.
- R7: SAMPLE/PRELOAD (010) selects the boundary chain and captures `pin_in` in Capture-DR, with `pin_in[0]` first out on `tdo`. Update-DR loads the latches, with the first bit shifted in landing in latch bit 0. The pins keep following the core and `sys_rst_req` stays 0.
- R8: CLAMP (110) selects the bypass stage and drives the pins from the update latches with every `pin_oe` bit 1. `sys_rst_req` is 0. A DR scan leaves the latches unchanged.
- R9: The bypass stage captures 0 in Capture-DR and delays `tdi` by one shift.
- R10: The codes 111, 011, 100 and 101 all behave as BYPASS: bypass stage selected, pins follow the core, no reset request.
- R11: The active instruction changes only on the falling `tck` edge in Update-IR (or in Test-Logic-Reset). Shifting in a new code leaves the outputs unchanged until then.
- R12: `tdo` and `tdo_en` change on the falling `tck` edge. `tdo_en` is 1 only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | Serial output enable, high in the shift states |
| core_out | input | NUM_PINS | Core output values |
| core_oe | input | NUM_PINS | Core output enables |
| pin_in | input | NUM_PINS | Values observed at the pins |
| pin_out | output | NUM_PINS | Values driven to the pins |
| pin_oe | output | NUM_PINS | Pin driver enables |
| sys_rst_req | output | 1 | Internal system reset request |

## Verification
Loading EXTEST makes two things happen on the same falling edge in Update-IR: the pin values switch from the core to the preloaded latches, and the reset request rises. The bench first preloads the latches with SAMPLE/PRELOAD. It then shifts in the EXTEST code and checks in Exit1-IR that neither the pins nor the reset request have moved. One clock later it checks that both changed together. A second collision is a TMS-driven reset while HIGHZ is active: it is provoked from inside Shift-DR. The bench checks that the reset request holds after four high edges and drops together with the pin-enable override on the fifth.

// File: rtl/scan_pkg.sv
package scan_pkg;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b010;
  localparam logic [IR_W-1:0] OP_CLAMP  = 3'b110;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
  // capture pattern doubles as the float-all-pins opcode
  localparam logic [IR_W-1:0] IR_CAPTURE = OP_HIGHZ;

  typedef enum logic [3:0] {
    ST_RESET   = 4'h0, ST_IDLE    = 4'h1,
    ST_SEL_DR  = 4'h2, ST_CAP_DR  = 4'h3, ST_SH_DR  = 4'h4,
    ST_EX1_DR  = 4'h5, ST_PAU_DR  = 4'h6, ST_EX2_DR = 4'h7, ST_UPD_DR = 4'h8,
    ST_SEL_IR  = 4'h9, ST_CAP_IR  = 4'hA, ST_SH_IR  = 4'hB,
    ST_EX1_IR  = 4'hC, ST_PAU_IR  = 4'hD, ST_EX2_IR = 4'hE, ST_UPD_IR = 4'hF
  } tap_state_t;

  typedef struct packed {
    logic sel_bsr;    // boundary chain is the data register
    logic rst_req;    // hold the core in reset
    logic hiz;        // disable every pin driver
    logic use_latch;  // pins driven from update latches
  } scan_ctl_t;

  function automatic tap_state_t tap_next(input tap_state_t s, input logic tms);
    tap_state_t n;
    case (s)
      ST_RESET:  n = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   n = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: n = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: n = tms ? ST_SEL_DR : ST_IDLE;
      default:   n = ST_RESET;
    endcase
    return n;
  endfunction

  function automatic scan_ctl_t decode_op(input logic [IR_W-1:0] op);
    scan_ctl_t c;
    case (op)
      OP_EXTEST: c = '{sel_bsr: 1'b1, rst_req: 1'b1, hiz: 1'b0, use_latch: 1'b1};
      OP_HIGHZ:  c = '{sel_bsr: 1'b0, rst_req: 1'b1, hiz: 1'b1, use_latch: 1'b0};
      OP_SAMPLE: c = '{sel_bsr: 1'b1, rst_req: 1'b0, hiz: 1'b0, use_latch: 1'b0};
      OP_CLAMP:  c = '{sel_bsr: 1'b0, rst_req: 1'b0, hiz: 1'b0, use_latch: 1'b1};
      default:   c = '{sel_bsr: 1'b0, rst_req: 1'b0, hiz: 1'b0, use_latch: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);

  tap_state_t state_q;
  logic [2:0] tms_ones_q;  // consecutive high tms edges, saturating at 5

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state_q    <= ST_RESET;
      tms_ones_q <= 3'd0;
    end else begin
      state_q    <= tap_next(state_q, tms);
      if (!tms)                  tms_ones_q <= 3'd0;
      else if (tms_ones_q != 3'd5) tms_ones_q <= tms_ones_q + 3'd1;
    end
  end

  assign state = state_q;

  // R3
  tms_five_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (tms_ones_q == 3'd5) |-> (state_q == ST_RESET));

endmodule

// File: rtl/instr_reg.sv
module instr_reg
  import scan_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_t      state,
  output logic            shift_bit,
  output logic [IR_W-1:0] active_op
);

  logic [IR_W-1:0] sr_q;
  logic [IR_W-1:0] op_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                  sr_q <= IR_CAPTURE;
    else if (state == ST_CAP_IR)  sr_q <= IR_CAPTURE;
    else if (state == ST_SH_IR)   sr_q <= {tdi, sr_q[IR_W-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                  op_q <= OP_BYPASS;
    else if (state == ST_RESET)   op_q <= OP_BYPASS;
    else if (state == ST_UPD_IR)  op_q <= sr_q;
  end

  assign shift_bit = sr_q[0];
  assign active_op = op_q;

  // R4
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $past(state == ST_CAP_IR) |-> (sr_q == 3'b001));
  // R2
  ir_reset_value_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_RESET) |-> (op_q == 3'b111));
  // R11
  ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_UPD_IR && state != ST_RESET) |-> $stable(op_q));

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import scan_pkg::*;
#(
  parameter int NUM_CELLS = 8
) (
  input  logic                 tck,
  input  logic                 trst_n,
  input  logic                 tdi,
  input  tap_state_t           state,
  input  logic                 sel,
  input  logic [NUM_CELLS-1:0] pin_in,
  output logic                 shift_bit,
  output logic [NUM_CELLS-1:0] latch_q
);

  localparam int LAST = NUM_CELLS - 1;

  logic [NUM_CELLS-1:0] cap_q;
  logic [NUM_CELLS-1:0] feed;
  logic                 do_cap, do_shift, do_upd;

  assign do_cap   = sel && (state == ST_CAP_DR);
  assign do_shift = sel && (state == ST_SH_DR);
  assign do_upd   = sel && (state == ST_UPD_DR);

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    if (i == LAST) begin : g_head
      assign feed[i] = tdi;
    end else begin : g_body
      assign feed[i] = cap_q[i+1];
    end

    always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)       cap_q[i] <= 1'b0;
      else if (do_cap)   cap_q[i] <= pin_in[i];
      else if (do_shift) cap_q[i] <= feed[i];
    end

    always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)     latch_q[i] <= 1'b0;
      else if (do_upd) latch_q[i] <= cap_q[i];
    end
  end

  assign shift_bit = cap_q[0];

  // R8
  latch_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !sel |-> $stable(latch_q));

endmodule

// File: rtl/scan_port.sv
module scan_port
  import scan_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                tms,
  input  logic                tdi,
  output logic                tdo,
  output logic                tdo_en,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                sys_rst_req
);

  tap_state_t          state;
  logic [IR_W-1:0]     active_op;
  scan_ctl_t           ctl;
  logic                ir_bit, bsr_bit;
  logic                byp_q;
  logic                tdo_q, tdo_en_q;
  logic [NUM_PINS-1:0] latch_q;
  logic                in_shift;

  tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
  );

  instr_reg u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
    .shift_bit(ir_bit), .active_op(active_op)
  );

  assign ctl = decode_op(active_op);

  bsr_chain #(.NUM_CELLS(NUM_PINS)) u_bsr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
    .sel(ctl.sel_bsr), .pin_in(pin_in),
    .shift_bit(bsr_bit), .latch_q(latch_q)
  );

  // one-stage bypass path
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                                   byp_q <= 1'b0;
    else if (!ctl.sel_bsr && state == ST_CAP_DR)   byp_q <= 1'b0;
    else if (!ctl.sel_bsr && state == ST_SH_DR)    byp_q <= tdi;
  end

  assign in_shift = (state == ST_SH_IR) || (state == ST_SH_DR);

  // serial output retimed to the falling edge
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_en_q <= in_shift;
      if (state == ST_SH_IR)      tdo_q <= ir_bit;
      else if (state == ST_SH_DR) tdo_q <= ctl.sel_bsr ? bsr_bit : byp_q;
    end
  end

  assign tdo         = tdo_q;
  assign tdo_en      = tdo_en_q;
  assign sys_rst_req = ctl.rst_req;
  assign pin_out     = ctl.use_latch ? latch_q : core_out;
  assign pin_oe      = ctl.hiz ? '0 : (ctl.use_latch ? '1 : core_oe);

  // R5
  extest_drive_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (active_op == 3'b000) |-> (sys_rst_req && pin_oe == '1 && pin_out == latch_q));
  // R6
  highz_float_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (active_op == 3'b001) |-> (sys_rst_req && pin_oe == '0));
  // R9
  bypass_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $past(state == ST_CAP_DR && !ctl.sel_bsr) |-> (byp_q == 1'b0));

endmodule

// File: tb/tb_scan_port.sv
module tb_scan_port;
  localparam int NB = 8;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_en, sys_rst_req;
  logic [NB-1:0] core_out = 8'hC3, core_oe = 8'h0F, pin_in = 8'h00;
  logic [NB-1:0] pin_out, pin_oe;
  int checks = 0, failures = 0;
  bit done = 0;

  scan_port #(.NUM_PINS(NB)) dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .core_out(core_out), .core_oe(core_oe), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .sys_rst_req(sys_rst_req)
  );

  always #10 tck = ~tck;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic tick(input logic t, input logic d);
    tms = t; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic pins_normal(input string req);
    chk({req, " pin_out"}, pin_out, core_out);
    chk({req, " pin_oe"}, pin_oe, core_oe);
    chk({req, " sys_rst_req"}, sys_rst_req, 0);
  endtask

  // from Run-Test/Idle, load an opcode; returns bits seen on tdo
  task automatic load_ir(input logic [2:0] code, output logic [2:0] seen);
    logic rst_before;
    logic [NB-1:0] out_before, oe_before;
    rst_before = sys_rst_req; out_before = pin_out; oe_before = pin_oe;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R12 tdo_en in Shift-IR", tdo_en, 1);
    for (int i = 0; i < 3; i++) begin
      seen[i] = tdo;
      tick(i == 2, code[i]);
    end
    chk("R12 tdo_en in Exit1-IR", tdo_en, 0);
    chk("R11 reset req before update", sys_rst_req, rst_before);
    chk("R11 pin_out before update", pin_out, out_before);
    chk("R11 pin_oe before update", pin_oe, oe_before);
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(input logic [NB-1:0] din, input int n, output logic [NB-1:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge tck);
    #1;
    chk("R12 tdo_en in reset", tdo_en, 0);
    pins_normal("R2 reset");
    trst_n = 1'b1;
    tick(1, 0);
    pins_normal("R2 Test-Logic-Reset");
    tick(0, 0);
  endtask

  task automatic t_ir_capture();
    logic [2:0] seen;
    load_ir(3'b111, seen);
    chk("R4 R1 captured IR bits lsb first", seen, 3'b001);
    pins_normal("R10 bypass 111");
  endtask

  task automatic t_bypass();
    logic [NB-1:0] o;
    scan_dr(8'b0000_1101, 4, o);
    chk("R9 bypass capture and delay", o[3:0], 4'b1010);
  endtask

  task automatic t_sample();
    logic [2:0] s;
    logic [NB-1:0] o;
    load_ir(3'b010, s);
    pins_normal("R7 sample no disturb");
    pin_in = 8'hA5;
    scan_dr(8'h3C, NB, o);
    chk("R7 sample capture", o, 8'hA5);
    pins_normal("R7 sample after preload");
  endtask

  task automatic t_extest();
    logic [2:0] s;
    logic [NB-1:0] o;
    load_ir(3'b000, s);
    chk("R5 extest pin_out from preload", pin_out, 8'h3C);
    chk("R5 extest pin_oe", pin_oe, 8'hFF);
    chk("R5 extest reset req", sys_rst_req, 1);
    pin_in = 8'h5A;
    scan_dr(8'h81, NB, o);
    chk("R5 extest capture", o, 8'h5A);
    chk("R5 extest update", pin_out, 8'h81);
  endtask

  task automatic t_clamp();
    logic [2:0] s;
    logic [NB-1:0] o;
    load_ir(3'b110, s);
    chk("R8 clamp pin_out", pin_out, 8'h81);
    chk("R8 clamp pin_oe", pin_oe, 8'hFF);
    chk("R8 clamp reset req", sys_rst_req, 0);
    scan_dr(8'h01, 2, o);
    chk("R8 clamp bypass path", o[1:0], 2'b10);
    chk("R8 clamp latches unchanged", pin_out, 8'h81);
  endtask

  task automatic t_highz_no_shift();
    tick(1, 0); tick(1, 0); tick(0, 0); tick(1, 0); tick(1, 0); tick(0, 0);
    chk("R4 R6 highz pin_oe", pin_oe, 8'h00);
    chk("R6 highz reset req", sys_rst_req, 1);
  endtask

  task automatic t_tms_reset();
    tick(1, 0); tick(0, 0); tick(0, 0);
    repeat (4) tick(1, 0);
    chk("R3 four high edges keep highz", sys_rst_req, 1);
    tick(1, 0);
    pins_normal("R3 R2 fifth high edge");
    tick(0, 0);
  endtask

  task automatic t_unlisted(input logic [2:0] code);
    logic [2:0] s;
    logic [NB-1:0] o;
    load_ir(code, s);
    pins_normal("R10 unlisted code");
    scan_dr(8'b0000_0101, 3, o);
    chk("R10 unlisted code bypass path", o[2:0], 3'b010);
  endtask

  initial begin
    #(20 * 150000);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_ir_capture();
    t_bypass();
    t_sample();
    t_extest();
    t_clamp();
    t_highz_no_shift();
    t_tms_reset();
    t_unlisted(3'b011);
    t_unlisted(3'b100);
    finish_run();
  end
endmodule